// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block answers a two-wire serial bus master as if it were a small serial EEPROM. It runs on a fast system clock. The clock line and the data line enter through two-flop synchronisers, and the block finds clock edges and bus conditions on those synchronised copies. It never drives the data line high. Its single output asks the pad to pull the line low, and an external pull-up restores the high level.

A transaction opens with an address byte: seven bits of device identity, then a direction bit. A write-direction transaction continues with a memory address of one or two bytes (set by a parameter), which loads an internal pointer. Any further bytes are stored at that pointer.

A read-direction transaction returns bytes from the pointer until the master declines with a NACK. A repeated START placed after the memory address keeps the pointer, so a write-addressed preamble followed by a read-direction address byte performs a random read. Storage is an internal register array whose depth is a parameter. The system clock must run at least eight times faster than SCL.

Top module: `i2c_eeprom_target`

## Requirements
- R1: With SCL high, a falling SDA is a START. A START restarts address reception from any state. A rising SDA with SCL high is a STOP, which releases SDA and makes the block idle.
- R2: If the seven upper bits of the first byte after START equal `DEV_ADDR`, the block pulls SDA low for the ninth clock. Otherwise it leaves SDA released and ignores the bus until the next START.
- R3: The least significant bit of the address byte selects the direction: 0 is write, 1 is read.
- R4: After a write-direction address, the block takes `ADDR_BYTES` memory address bytes, high byte first, and acknowledges each one. Only the low log2(`MEM_DEPTH`) bits of the assembled address reach the pointer.
- R5: A data byte received after the memory address is stored at the pointer and acknowledged.
- R6: In page write, each stored byte advances the pointer within its `PAGE_SIZE`-aligned page. After the last byte of a page, the pointer wraps to the first byte of the same page.
- R7: A repeated START leaves the pointer unchanged. A read-direction address byte then returns the byte at the previously supplied address.
- R8: In read mode, bytes go out MSB first and SDA is released on the ninth clock. A master ACK (SDA low) makes the block send the next byte. The pointer wraps from the top of memory to 0. A master NACK (SDA high) ends the transfer with SDA released.
- R9: The block only pulls SDA low, and it starts pulling only while SCL is low. It releases SDA while SCL is high only at a START or a STOP.
- R10: After reset, SDA is released and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |

## Verification
The bench aims at the following corners:

- **Page boundary.** A page write runs across a page boundary. A design that carries into the upper address bits writes into the next page instead of wrapping.
- **Top of memory.** A sequential read starts two bytes below the top of memory. A design that stops or saturates there returns wrong bytes after the wrap instead of restarting at 0.
- **Repeated START.** A random read relies on the repeated START keeping the pointer. A design that resets the pointer returns location 0.
- **Foreign address.** A transaction to another device address must not be acknowledged, and its later bytes must be ignored. A design that latches the wrong bytes acknowledges them or corrupts memory.
- **Address truncation.** A two-byte address with high bits beyond the memory size is used. A design that handles these bits wrongly stores the byte at the wrong location.
- **Release after NACK.** The bench checks that SDA is released after the master NACK. A design that keeps driving would hold the line low into the STOP.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // ignore bus until START
    ST_DEV,    // receiving device address byte
    ST_AHI,    // receiving high memory address byte
    ST_ALO,    // receiving low memory address byte
    ST_WDATA,  // receiving data to store
    ST_RDATA   // transmitting stored data
  } ee_state_t;

  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] sync_o,
  output logic [LANES-1:0] prev_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;  // bus idles high
      else        chain <= {chain[STAGES-1:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
    assign prev_o[g] = chain[STAGES];
  end
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter int unsigned ADDR_BYTES = 2,
  parameter int unsigned MEM_DEPTH  = 256,
  parameter int unsigned PAGE_SIZE  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int unsigned AW    = $clog2(MEM_DEPTH);
  localparam int unsigned ABITS = ADDR_BYTES * BYTE_BITS;
  localparam logic [AW-1:0] PMASK = AW'(PAGE_SIZE - 1);

  // synchronised bus lines: lane 1 = SCL, lane 0 = SDA
  logic [1:0] lvl, lvl_q;
  i2c_ee_sync #(.LANES(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({scl_i, sda_i}),
    .sync_o(lvl), .prev_o(lvl_q)
  );

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = lvl[1];
  assign sda_s     = lvl[0];
  assign scl_rise  =  lvl[1] & ~lvl_q[1];
  assign scl_fall  = ~lvl[1] &  lvl_q[1];
  assign start_det =  lvl[1] & lvl_q[1] &  lvl_q[0] & ~lvl[0];
  assign stop_det  =  lvl[1] & lvl_q[1] & ~lvl_q[0] &  lvl[0];

  ee_state_t     state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [7:0]    addr_hi;
  logic [AW-1:0] ptr;
  logic          rw_q, nack_q, pull_q;

  // assembled memory address
  logic [ABITS-1:0] full_addr;
  if (ADDR_BYTES == 2) begin : g_two_byte
    assign full_addr = {addr_hi, shreg};
  end else begin : g_one_byte
    assign full_addr = shreg;
  end

  logic [AW-1:0] ptr_page_next, ptr_lin_next;
  assign ptr_page_next = (ptr & ~PMASK) | ((ptr + 1'b1) & PMASK);
  assign ptr_lin_next  = ptr + 1'b1;

  logic       byte_end, ack_end, mem_we;
  logic [7:0] rdata;
  assign byte_end = scl_fall && (bit_cnt == 4'd8) && !start_det && !stop_det;
  assign ack_end  = scl_fall && (bit_cnt == 4'd9) && !start_det && !stop_det;
  assign mem_we   = byte_end && (state == ST_WDATA);

  i2c_ee_mem #(.DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(ptr),
    .wdata(shreg), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      pull_q  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      pull_q  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < 4'd8) begin
          if (state != ST_RDATA) shreg <= {shreg[6:0], sda_s};
        end else if (state == ST_RDATA) begin
          nack_q <= sda_s;
        end
      end
      if (byte_end) begin
        unique case (state)
          ST_DEV: begin
            if (shreg[7:1] == DEV_ADDR) begin
              pull_q <= 1'b1;
              rw_q   <= shreg[0];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_AHI:   begin addr_hi <= shreg; pull_q <= 1'b1; end
          ST_ALO:   begin ptr <= full_addr[AW-1:0]; pull_q <= 1'b1; end
          ST_WDATA: begin ptr <= ptr_page_next; pull_q <= 1'b1; end
          ST_RDATA: begin ptr <= ptr_lin_next; pull_q <= 1'b0; end
          default:  ;
        endcase
      end else if (ack_end) begin
        bit_cnt <= '0;
        pull_q  <= 1'b0;
        unique case (state)
          ST_DEV: begin
            if (rw_q) begin
              state  <= ST_RDATA;
              shreg  <= rdata;
              pull_q <= ~rdata[7];
            end else begin
              state <= (ADDR_BYTES == 2) ? ST_AHI : ST_ALO;
            end
          end
          ST_AHI:   state <= ST_ALO;
          ST_ALO:   state <= ST_WDATA;
          ST_WDATA: state <= ST_WDATA;
          ST_RDATA: begin
            if (nack_q) begin
              state <= ST_IDLE;
            end else begin
              shreg  <= rdata;
              pull_q <= ~rdata[7];
            end
          end
          default: ;
        endcase
      end else if (scl_fall && state == ST_RDATA && bit_cnt != 4'd0) begin
        shreg  <= {shreg[6:0], 1'b0};
        pull_q <= ~shreg[6];
      end
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_pull,
  input logic [3:0] bit_cnt
);
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  a_r1_start_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == 4'd0));

  a_r9_pull_begins_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  a_r9_release_high_only_cond: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && scl_lvl) |-> $past(start_det || stop_det));

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd9);
endmodule

bind i2c_eeprom_target i2c_ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(pull_q), .bit_cnt(bit_cnt)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
  localparam int Q = 8;  // clocks per quarter bit
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_eeprom_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  int checks = 0, fails = 0, r9_bad = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] page_next(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
    end
    sda_m = 1'b1; qw(); scl = 1'b1; qw();
    acked = !sda_line;
    qw(); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0;
    end
    qw(); sda_m = !give_ack; scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] addr, input int n);
    bit a;
    logic [7:0] p;
    bus_start();
    send_byte({DEV, 1'b0}, a);  check(a, "R2 dev ack (write)", a, 1);
    send_byte(addr[15:8], a);   check(a, "R4 addr hi ack", a, 1);
    send_byte(addr[7:0], a);    check(a, "R4 addr lo ack", a, 1);
    p = addr[7:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);    check(a, "R5 data ack", a, 1);
      ref_mem[p] = wbuf[i];
      p = page_next(p);         // R6 wrap inside page
    end
    bus_stop();
    check(!sda_pull, "R1 released after stop", sda_pull, 0);
  endtask

  task automatic do_read(input logic [15:0] addr, input int n);
    bit a;
    bus_start();
    send_byte({DEV, 1'b0}, a);  check(a, "R3 write-direction ack", a, 1);
    send_byte(addr[15:8], a);
    send_byte(addr[7:0], a);
    bus_start();                // repeated START, R7
    send_byte({DEV, 1'b1}, a);  check(a, "R3 read-direction ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    check(!sda_pull, "R8 released after NACK", sda_pull, 0);
    bus_stop();
  endtask

  task automatic verify(input logic [7:0] start, input int n, input string tag);
    logic [7:0] p = start;
    for (int i = 0; i < n; i++) begin
      check(rbuf[i] == ref_mem[p], tag, rbuf[i], ref_mem[p]);
      p = p + 8'd1;             // R8 wrap at top
    end
  endtask

  // R9: pull may only begin while SCL is low
  logic pull_d = 1'b0;
  always @(negedge clk) begin
    if (sda_pull && !pull_d && scl) r9_bad++;
    pull_d <= sda_pull;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!sda_pull, "R10 reset releases SDA", sda_pull, 0);

    do_read(16'h0005, 1);
    verify(8'h05, 1, "R10 reset memory zero");

    // foreign device address: no ack, rest ignored
    bus_start();
    send_byte({7'h51, 1'b0}, a); check(!a, "R2 no ack for other device", a, 0);
    send_byte(8'h00, a);         check(!a, "R2 later byte ignored", a, 0);
    send_byte(8'h10, a);
    send_byte(8'hEE, a);         check(!a, "R2 data ignored", a, 0);
    bus_stop();
    do_read(16'h0010, 1);
    verify(8'h10, 1, "R2 memory untouched");

    // single-byte write + random read
    wbuf[0] = 8'hA5;
    do_write(16'h0042, 1);
    do_read(16'h0042, 1);
    verify(8'h42, 1, "R5 R7 single write random read");

    // address truncation
    wbuf[0] = 8'h3C;
    do_write(16'h1234, 1);
    do_read(16'h0034, 1);
    verify(8'h34, 1, "R4 upper address bits dropped");

    // page write across page boundary
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h80 + 8'(i);
    do_write(16'h001D, 5);
    do_read(16'h0010, 8);
    verify(8'h10, 8, "R6 page wrap low part");
    do_read(16'h001D, 3);
    verify(8'h1D, 3, "R6 page tail");
    do_read(16'h0020, 1);
    verify(8'h20, 1, "R6 next page untouched");

    // sequential read across top of memory
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(16'h00FE, 2);
    wbuf[0] = 8'h33;
    do_write(16'h0000, 1);
    do_read(16'h00FE, 4);
    verify(8'hFE, 4, "R8 sequential wrap at top");

    // STOP in the middle of a byte releases and ends
    bus_start();
    send_byte({DEV, 1'b0}, a);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
    bus_stop();
    check(!sda_pull, "R1 stop mid-byte releases", sda_pull, 0);

    // constrained random write/read mix
    for (int t = 0; t < 20; t++) begin
      logic [7:0] ad;
      int n;
      ad = 8'($urandom_range(0, 255));
      n  = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write({8'($urandom), ad}, n);
      do_read({8'h00, ad}, n);
      verify(ad, n, "R6 R8 random readback");
    end

    check(r9_bad == 0, "R9 pull began with SCL high", r9_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule